// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Idle Preamble

This block is the sending side of an asynchronous serial link. Software, or a bus master acting for it, places one character into a holding register. The block moves that character into a frame shift register and sends it on a single output line. Each frame is a low start bit, then the data bits with the least significant bit first, then a high stop bit. A control bit picks either 8 or 9 data bits. In 9-bit mode the extra data bit comes from its own control bit and not from the holding register. The block does not divide a clock down to the baud rate. Instead, an external one-cycle `bit_tick` pulse marks every bit period, and the line moves only on those pulses.

When the enable bit goes from 0 to 1, the block first sends one whole character time of high level as a preamble, and only then sends data. Two status flags report progress. `empty_flag` shows the holding register can take a new character. `done_flag` shows the line has gone quiet after the last frame. Each flag has its own mask into a single interrupt output. A break request holds the line low for whole character times. After the request is withdrawn, the block sends at least one high bit before it resumes normal traffic.

Top module: `async_tx`

## Requirements
- R1: After reset, `txd` is 1, `empty_flag` is 1, `done_flag` is 1, `irq` is 0, and every control bit is 0.
- R2: A data frame is sent one bit per `bit_tick`, in this order: a 0 start bit, the data bits least significant first, then a 1 stop bit. With mode bit `wr_ctrl[2]` = 0 the frame is 10 bits long, and the value of `wr_ctrl[3]` has no effect on it.
- R3: With `wr_ctrl[2]` = 1 the frame is 11 bits long, and the ninth data bit (frame position 9) equals control bit `wr_ctrl[3]`.
- R4: A control write that changes the enable bit `wr_ctrl[0]` from 0 to 1 causes one full frame length of 1 bits to be sent before any data frame starts.
- R5: A data write clears `empty_flag`. `empty_flag` sets again on the same tick on which that character's start bit appears on `txd`.
- R6: `done_flag` clears on a data write. It sets on the tick that ends a frame when nothing follows. It stays 0 when a waiting character follows directly after the current frame.
- R7: `irq` is 1 exactly when (`wr_ctrl[4]` and `empty_flag`) or (`wr_ctrl[5]` and `done_flag`) holds.
- R8: While the enabled block has break bit `wr_ctrl[1]` set, `txd` is 0 for whole frame lengths. Once the bit clears, the running break frame completes, then one 1 bit is sent, and only after that can a waiting character start.
- R9: Clearing the enable bit lets the frame in progress complete. After that `txd` stays 1 and a waiting character stays in the holding register (`empty_flag` = 0) until the block is enabled again, and that re-enable brings a preamble first.
- R10: Without a `bit_tick` pulse, the line and the holding register do not advance. A waiting character does not start until the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| wr_data_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| wr_ctrl_en | input | 1 | Write strobe for the control bits |
| wr_ctrl | input | 6 | [0] enable, [1] break, [2] 9-bit mode, [3] ninth bit, [4] empty interrupt mask, [5] done interrupt mask |
| txd | output | 1 | Serial line, high when idle |
| empty_flag | output | 1 | Holding register may be written |
| done_flag | output | 1 | Line is quiet after the last frame |
| irq | output | 1 | Masked interrupt request |

## Verification
Most internal faults in this block show up on `txd` within one frame. A miscounted bit counter shifts the stop bit or the next start bit by one tick. A preamble flag that is lost, or that fires on a repeated enable write, adds or removes ten or eleven high bits before the first start bit. The holding-register handshake shows its faults at the frame boundary: `empty_flag` rising on the wrong tick, or `done_flag` pulsing high between back-to-back frames, is visible on the boundary tick itself. A break tail that is dropped is visible as a start bit that comes one tick too early.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  // control word, msb first: bit 0 is the enable
  typedef struct packed {
    logic ie_done;
    logic ie_empty;
    logic bit8;
    logic nine;
    logic brk;
    logic en;
  } tx_ctrl_t;

  localparam int CTRL_W = $bits(tx_ctrl_t);

  // what the frame engine loads at a frame boundary
  typedef enum logic [2:0] {
    NXT_IDLE,
    NXT_PRE,
    NXT_BRK,
    NXT_STOP,
    NXT_DATA
  } nxt_e;

endpackage

// File: rtl/tx_ctrl_reg.sv
module tx_ctrl_reg
  import async_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output tx_ctrl_t          ctrl,
  output logic              en_rise
);

  tx_ctrl_t wr_word;
  assign wr_word = tx_ctrl_t'(wdata);

  // enable goes 0 -> 1 with this write
  assign en_rise = wr && wr_word.en && !ctrl.en;

  always_ff @(posedge clk) begin
    if (!rst_n)  ctrl <= '0;
    else if (wr) ctrl <= wr_word;
  end

endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              take,
  output logic [DATA_W-1:0] data,
  output logic              full
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data <= '0;
      full <= 1'b0;
    end else begin
      if (wr) data <= wdata;
      if (wr)        full <= 1'b1;
      else if (take) full <= 1'b0;
    end
  end

endmodule

// File: rtl/tx_frame_eng.sv
module tx_frame_eng
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  tx_ctrl_t          ctrl,
  input  logic              en_rise,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              txd,
  output logic              take,
  output logic              idle_end
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  // bits in one character time: start + data (+ ninth) + stop
  function automatic logic [CNT_W-1:0] frame_len(input logic nine);
    return CNT_W'(DATA_W + 2) + CNT_W'(nine);
  endfunction

  // frame image, bit 0 leaves the block first
  function automatic logic [FRAME_W-1:0] build_frame(
    input logic [DATA_W-1:0] d, input logic b8, input logic nine);
    logic [FRAME_W-1:0] f;
    f            = '1;
    f[0]         = 1'b0;
    f[DATA_W:1]  = d;
    if (nine) f[DATA_W+1] = b8;
    return f;
  endfunction

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   cnt;
  logic               pre_pend;
  logic               brk_tail;
  logic               adv;
  nxt_e               nxt;

  // a frame boundary: last bit ending or line idle
  assign adv = bit_tick && (cnt <= CNT_W'(1));

  always_comb begin
    if (pre_pend && ctrl.en)        nxt = NXT_PRE;
    else if (ctrl.brk && ctrl.en)   nxt = NXT_BRK;
    else if (brk_tail)              nxt = NXT_STOP;
    else if (hold_full && ctrl.en)  nxt = NXT_DATA;
    else                            nxt = NXT_IDLE;
  end

  assign take     = adv && (nxt == NXT_DATA);
  assign idle_end = adv && (nxt == NXT_IDLE) && (cnt == CNT_W'(1));
  assign txd      = (cnt != '0) ? sh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh       <= '1;
      cnt      <= '0;
      pre_pend <= 1'b0;
      brk_tail <= 1'b0;
    end else begin
      if (en_rise)                       pre_pend <= 1'b1;
      else if (!ctrl.en)                 pre_pend <= 1'b0;
      else if (adv && nxt == NXT_PRE)    pre_pend <= 1'b0;

      if (adv) begin
        case (nxt)
          NXT_PRE:  begin sh <= '1; cnt <= frame_len(ctrl.nine); end
          NXT_BRK:  begin sh <= '0; cnt <= frame_len(ctrl.nine); brk_tail <= 1'b1; end
          NXT_STOP: begin sh <= '1; cnt <= CNT_W'(1); brk_tail <= 1'b0; end
          NXT_DATA: begin
            sh  <= build_frame(hold_data, ctrl.bit8, ctrl.nine);
            cnt <= frame_len(ctrl.nine);
          end
          default:  begin sh <= '1; cnt <= '0; end
        endcase
      end else if (bit_tick) begin
        sh  <= {1'b1, sh[FRAME_W-1:1]};
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  // R10
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(cnt) && $stable(sh));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_W));

  // R8
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && nxt == NXT_BRK) |=> !txd);

  // R9
  dis_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ctrl.en && !brk_tail) |=> txd);

endmodule

// File: rtl/tx_status.sv
module tx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic data_wr,
  input  logic idle_end,
  input  logic empty,
  input  logic ie_empty,
  input  logic ie_done,
  output logic done,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rst_n)        done <= 1'b1;
    else if (data_wr)  done <= 1'b0;
    else if (idle_end) done <= 1'b1;
  end

  assign irq = (ie_empty && empty) || (ie_done && done);

  // R6
  done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !done);

endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              wr_data_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ctrl_en,
  input  logic [CTRL_W-1:0] wr_ctrl,
  output logic              txd,
  output logic              empty_flag,
  output logic              done_flag,
  output logic              irq
);

  tx_ctrl_t          ctrl;
  logic              en_rise;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              idle_end;

  tx_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(wr_ctrl_en), .wdata(wr_ctrl),
    .ctrl(ctrl), .en_rise(en_rise)
  );

  tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr(wr_data_en), .wdata(wr_data),
    .take(take), .data(hold_data), .full(hold_full)
  );

  tx_frame_eng #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ctrl(ctrl),
    .en_rise(en_rise), .hold_full(hold_full), .hold_data(hold_data),
    .txd(txd), .take(take), .idle_end(idle_end)
  );

  assign empty_flag = !hold_full;

  tx_status u_stat (
    .clk(clk), .rst_n(rst_n), .data_wr(wr_data_en), .idle_end(idle_end),
    .empty(empty_flag), .ie_empty(ctrl.ie_empty), .ie_done(ctrl.ie_done),
    .done(done_flag), .irq(irq)
  );

  // R5
  take_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> hold_full);

  // R5
  empty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_data_en) |=> empty_flag);

endmodule

// File: tb/tb_async_tx.sv
`timescale 1ns/1ps
module tb_async_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       wr_data_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ctrl_en = 1'b0;
  logic [5:0] wr_ctrl = '0;
  logic       txd, empty_flag, done_flag, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  async_tx #(.DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .wr_data_en(wr_data_en), .wr_data(wr_data),
    .wr_ctrl_en(wr_ctrl_en), .wr_ctrl(wr_ctrl),
    .txd(txd), .empty_flag(empty_flag), .done_flag(done_flag), .irq(irq)
  );

  // {nine, bit8, data}
  localparam logic [9:0] VEC [0:5] = '{
    10'h0A5, 10'h0FF, 10'h200, 10'h3C3, 10'h101, 10'h37E
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  task automatic wr_d(input logic [7:0] d);
    @(negedge clk) begin wr_data_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_data_en = 1'b0;
  endtask

  task automatic wr_c(input logic [5:0] c);
    @(negedge clk) begin wr_ctrl_en = 1'b1; wr_ctrl = c; end
    @(negedge clk) wr_ctrl_en = 1'b0;
  endtask

  task automatic collect(input int n, output logic [31:0] v);
    v = '0;
    for (int i = 0; i < n; i++) begin
      do_tick();
      v[i] = txd;
    end
  endtask

  // expected line bits, position 0 first
  function automatic logic [31:0] exp_frame(input logic [7:0] d, input logic b8, input logic nine);
    logic [31:0] f;
    f = '0;
    for (int i = 0; i < 8; i++) f[i+1] = d[i];
    f[9] = nine ? b8 : 1'b1;
    if (nine) f[10] = 1'b1;
    return f;
  endfunction

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] got;
    logic [31:0] expv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 txd", {31'b0, txd}, 1);
    chk("R1 empty", {31'b0, empty_flag}, 1);
    chk("R1 done", {31'b0, done_flag}, 1);
    chk("R1 irq", {31'b0, irq}, 0);

    // R4 preamble after enable, then the character
    wr_c(6'b000001);
    wr_d(8'h3C);
    collect(20, got);
    expv = (exp_frame(8'h3C, 1'b0, 1'b0) << 10) | 32'h3FF;
    chk("R4 preamble+frame", got, expv);
    do_tick();
    chk("R6 done after frame", {31'b0, done_flag}, 1);

    // R2 R3 table walk
    for (int k = 0; k < 6; k++) begin
      logic nine, b8;
      logic [7:0] d;
      int nb;
      nine = VEC[k][9];
      b8   = VEC[k][8];
      d    = VEC[k][7:0];
      nb   = nine ? 11 : 10;
      wr_c({2'b00, b8, nine, 2'b01});
      wr_d(d);
      chk("R5 empty clears", {31'b0, empty_flag}, 0);
      chk("R6 done clears", {31'b0, done_flag}, 0);
      got = '0;
      for (int i = 0; i < nb; i++) begin
        do_tick();
        got[i] = txd;
        if (i == 0) chk("R5 empty at start bit", {31'b0, empty_flag}, 1);
      end
      chk(nine ? "R3 nine-bit frame" : "R2 eight-bit frame", got, exp_frame(d, b8, nine));
      do_tick();
      chk("R6 done at end", {31'b0, done_flag}, 1);
      chk("R2 idle high", {31'b0, txd}, 1);
    end

    // R7 masked interrupt
    wr_c(6'b000001);
    chk("R7 no mask", {31'b0, irq}, 0);
    wr_c(6'b010001);
    chk("R7 empty mask", {31'b0, irq}, 1);
    wr_c(6'b100001);
    chk("R7 done mask", {31'b0, irq}, 1);
    wr_c(6'b110001);
    wr_d(8'h11);
    chk("R7 both flags low", {31'b0, irq}, 0);
    do_tick();
    chk("R7 empty raises irq", {31'b0, irq}, 1);
    collect(10, got);
    wr_c(6'b000001);

    // R6 back to back frames
    wr_d(8'hA1);
    do_tick();
    got = '0;
    got[0] = txd;
    wr_d(8'h6B);
    chk("R5 second write", {31'b0, empty_flag}, 0);
    for (int i = 1; i < 20; i++) begin
      do_tick();
      got[i] = txd;
      if (i == 10) begin
        chk("R6 done stays low", {31'b0, done_flag}, 0);
        chk("R5 empty at second start", {31'b0, empty_flag}, 1);
      end
    end
    chk("R2 back to back", got, (exp_frame(8'h6B, 1'b0, 1'b0) << 10) | exp_frame(8'hA1, 1'b0, 1'b0));
    do_tick();

    // R8 break then stop bit then data
    wr_c(6'b000011);
    wr_d(8'h55);
    got = '0;
    for (int i = 0; i < 3; i++) begin do_tick(); got[i] = txd; end
    wr_c(6'b000001);
    for (int i = 3; i < 21; i++) begin do_tick(); got[i] = txd; end
    chk("R8 break sequence", got, (exp_frame(8'h55, 1'b0, 1'b0) << 11) | 32'h400);
    do_tick();
    chk("R8 done after break data", {31'b0, done_flag}, 1);

    // R9 disable mid frame
    wr_d(8'hF0);
    got = '0;
    for (int i = 0; i < 3; i++) begin do_tick(); got[i] = txd; end
    wr_c(6'b000000);
    for (int i = 3; i < 10; i++) begin do_tick(); got[i] = txd; end
    chk("R9 frame completes", got, exp_frame(8'hF0, 1'b0, 1'b0));
    wr_d(8'h0F);
    collect(6, got);
    chk("R9 line idles", got, 32'h3F);
    chk("R9 data held", {31'b0, empty_flag}, 0);
    wr_c(6'b000001);
    collect(20, got);
    chk("R9 R4 re-enable preamble", got, (exp_frame(8'h0F, 1'b0, 1'b0) << 10) | 32'h3FF);
    do_tick();

    // R10 no tick, no motion
    wr_d(8'h80);
    repeat (30) @(negedge clk);
    chk("R10 line held", {31'b0, txd}, 1);
    chk("R10 data waiting", {31'b0, empty_flag}, 0);
    do_tick();
    chk("R10 start on tick", {31'b0, txd}, 0);
    collect(10, got);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule